// File: doc/BRIEF.md
# Single-Wire ROM Command Selector

This block is the network layer of a slave on a single-wire, open-drain bus. A bit engine underneath it turns line activity into strobes: a bus-reset strobe, a written-bit strobe carrying the master's bit, and a read-slot strobe that tells the selector a read slot has just used the bit it was offering. The selector answers every bus reset with a one-cycle presence request. It then takes one 8-bit ROM command, least significant bit first, and handles it against the 64-bit device identifier given on `dev_id`.

The identifier has three parts: bits [7:0] are the family code, bits [55:8] the serial number and bits [63:56] the CRC. The five commands either select the device or send it to idle until the next bus reset. The five commands are read, match, skip, search and resume. When the device is selected, `selected` grants the function layer access to the bus. A sticky resume flag lets a master address the device again with a single command byte. A successful match or search sets this flag. Any command that addresses some other device, or all devices at once, clears it.

Top module: `rom_selector`

## Requirements
- R1: One cycle after a `bus_reset` strobe, `presence_pulse` is high for exactly one cycle and `selected` is low. After that, the block collects a command byte.
- R2: The command byte is built from eight `wr_valid` strobes, least significant bit first. The codes are read 8'h33, match 8'h55, search 8'hF0, skip 8'hCC and resume 8'hA5.
- R3: Read offers identifier bits 0 to 63 in order on `tx_bit`, one per `rd_done` strobe, with `tx_active` high. The read command clears the resume flag. After the 64th slot the device is selected.
- R4: Match compares 64 written bits with `dev_id`, bit 0 first. If all 64 bits are equal, `selected` and `resume_flag` are both set after the last bit.
- R5: On the first differing match bit, the resume flag is cleared and the device goes idle. Later bits cannot select it before a bus reset.
- R6: Search runs a triplet for each bit i, starting at bit 0. The first read slot offers `dev_id[i]`, the second offers its complement, and then the written bit is compared with `dev_id[i]`. After all 64 bits agree, `selected` and `resume_flag` are set.
- R7: When a written search bit differs from the identifier bit, the resume flag is cleared and the device drops out. From then on it leaves `tx_active` low and `tx_bit` high until a bus reset.
- R8: Skip selects the device on the edge of its eighth command bit and clears the resume flag.
- R9: Resume selects the device only when `resume_flag` is set, and it leaves the flag set. If the flag is clear, the device goes idle.
- R10: Any other command byte makes the device idle until a bus reset, and `resume_flag` keeps its value.
- R11: A `bus_reset` strobe in any state wins over every other input on that edge. It deasserts `selected` and restarts command collection, and it does not change `resume_flag`.
- R12: While the device is selected or idle, written bits and read slots have no effect: `tx_active` is low, `tx_bit` is high, and `selected` holds until a bus reset.
- R13: After `rst_n` the device is idle, not selected, with the resume flag clear. It ignores commands until the first `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id | input | ID_W | Device identifier: family [7:0], serial [55:8], CRC [63:56] |
| bus_reset | input | 1 | Bit-engine strobe: bus reset detected |
| wr_valid | input | 1 | Bit-engine strobe: master wrote a bit |
| wr_bit | input | 1 | Value of the bit the master wrote |
| rd_done | input | 1 | Bit-engine strobe: a read slot consumed `tx_bit` |
| presence_pulse | output | 1 | Request to the bit engine to send a presence pulse |
| tx_active | output | 1 | The selector is offering a bit for read slots |
| tx_bit | output | 1 | Bit for the next read slot; 1 (line released) when inactive |
| selected | output | 1 | Access granted to the function layer |
| resume_flag | output | 1 | Sticky resume flag |

## Verification
The bench sweeps all 256 command bytes twice, once with the resume flag cleared beforehand and once with it set. This catches a decoder that confuses a code, a resume that ignores the flag, and an unknown byte that disturbs the flag. A match is broken at each of the 64 bit positions. A design that stops comparing early, or lets later bits re-select the device, then selects a device that was never addressed. A search is abandoned at every position and run fully on several identifiers. A wrong complement, a bit order reversed, or a device that keeps driving after dropping out shows up at the ports. Bus resets are issued in the middle of reads and while the device is selected. A reset that fails to win over other inputs, or one that wipes the resume flag, is then visible.

// File: rtl/rs_pkg.sv
// Shared types and command codes for the ROM command selector.
// Assumes 8-bit command bytes received least significant bit first.
package rs_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_RESUME = 8'hA5;

    typedef enum logic [3:0] {
        S_OFF,       // idle until next bus reset
        S_PRES,      // presence request cycle
        S_CMD,       // collecting command byte
        S_READ,      // sending identifier
        S_MATCH,     // comparing written identifier
        S_SR_TRUE,   // search: offering true bit
        S_SR_COMP,   // search: offering complement bit
        S_SR_DIR,    // search: awaiting master's chosen bit
        S_SEL        // selected, function layer owns the bus
    } rs_state_t;

endpackage

// File: rtl/rs_cmd_shift.sv
// Command byte assembler: shifts in W written bits LSB first and flags
// the W-th bit combinationally, presenting the complete byte alongside.
// Assumes clr is asserted before each new byte.
module rs_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    // Count bits and shift them in from the top so bit 0 arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (en) begin
            cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
            sh  <= {bit_in, sh[W-1:1]};
        end
    end

    // The byte is complete on the strobe that carries its last bit.
    always_comb begin
        byte_done = en && (cnt == CW'(W-1));
        byte_val  = {bit_in, sh[W-1:1]};
    end
endmodule

// File: rtl/rs_bit_index.sv
// Identifier bit index: counts 0..N-1 on inc, cleared by clr.
// Assumes the controller never increments past the last position.
module rs_bit_index #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 inc,
    output logic [$clog2(N)-1:0] idx,
    output logic                 last
);
    localparam int IW = $clog2(N);

    // Advance the position through the identifier.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (inc && (idx != IW'(N-1))) begin
            idx <= idx + 1'b1;
        end
    end

    // Flag the final identifier position.
    always_comb last = (idx == IW'(N-1));
endmodule

// File: rtl/rs_fsm.sv
// ROM command controller: decodes the command byte, walks the identifier
// for read, match and search, and owns the resume flag and selection.
// Assumes single-cycle strobes from the bit engine and a dev_id that is
// stable during a transaction.
module rs_fsm
    import rs_pkg::*;
#(
    parameter int ID_W = 64,
    localparam int IW  = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  dev_id,
    input  logic             bus_reset,
    input  logic             wr_valid,
    input  logic             wr_bit,
    input  logic             rd_done,
    input  logic             byte_done,
    input  logic [CMD_W-1:0] byte_val,
    input  logic [IW-1:0]    idx,
    input  logic             last,
    output logic             cmd_clr,
    output logic             cmd_en,
    output logic             idx_clr,
    output logic             idx_inc,
    output logic             presence_pulse,
    output logic             selected,
    output logic             resume_flag,
    output logic             tx_active,
    output logic             tx_bit
);
    rs_state_t state, nxt;
    logic      res_nxt;
    logic      id_bit;

    assign id_bit = dev_id[idx];

    // Next-state and resume-flag decisions; bus reset overrides all.
    always_comb begin
        nxt     = state;
        res_nxt = resume_flag;
        idx_inc = 1'b0;
        unique case (state)
            S_OFF: ;
            S_PRES: nxt = S_CMD;
            S_CMD: begin
                if (byte_done) begin
                    unique case (byte_val)
                        OP_READ:   begin nxt = S_READ; res_nxt = 1'b0; end
                        OP_MATCH:  nxt = S_MATCH;
                        OP_SEARCH: nxt = S_SR_TRUE;
                        OP_SKIP:   begin nxt = S_SEL; res_nxt = 1'b0; end
                        OP_RESUME: nxt = resume_flag ? S_SEL : S_OFF;
                        default:   nxt = S_OFF;
                    endcase
                end
            end
            S_READ: begin
                if (rd_done) begin
                    if (last) nxt = S_SEL;
                    else      idx_inc = 1'b1;
                end
            end
            S_MATCH, S_SR_DIR: begin
                if (wr_valid) begin
                    if (wr_bit != id_bit) begin
                        nxt     = S_OFF;
                        res_nxt = 1'b0;
                    end else if (last) begin
                        nxt     = S_SEL;
                        res_nxt = 1'b1;
                    end else begin
                        idx_inc = 1'b1;
                        if (state == S_SR_DIR) nxt = S_SR_TRUE;
                    end
                end
            end
            S_SR_TRUE: if (rd_done) nxt = S_SR_COMP;
            S_SR_COMP: if (rd_done) nxt = S_SR_DIR;
            S_SEL: ;
            default: nxt = S_OFF;
        endcase
        if (bus_reset) begin
            nxt     = S_PRES;
            res_nxt = resume_flag;
            idx_inc = 1'b0;
        end
    end

    // State and resume flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_OFF;
            resume_flag <= 1'b0;
        end else begin
            state       <= nxt;
            resume_flag <= res_nxt;
        end
    end

    // Control strobes to the byte assembler and index counter.
    always_comb begin
        cmd_clr = (state == S_PRES);
        cmd_en  = (state == S_CMD) && wr_valid && !bus_reset;
        idx_clr = (state == S_PRES);
    end

    // Port-facing outputs decoded from the state.
    always_comb begin
        presence_pulse = (state == S_PRES);
        selected       = (state == S_SEL);
        tx_active      = (state == S_READ) || (state == S_SR_TRUE) || (state == S_SR_COMP);
        if (!tx_active)              tx_bit = 1'b1;
        else if (state == S_SR_COMP) tx_bit = ~id_bit;
        else                         tx_bit = id_bit;
    end

    AST_PRESENCE_FOLLOWS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> presence_pulse && !selected); // R1

    AST_RESUME_RISES_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_flag) |-> selected); // R4

    AST_MATCH_FAIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MATCH && wr_valid && (wr_bit != id_bit) && !bus_reset)
        |=> !resume_flag && !selected && !tx_active); // R5

    AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SR_COMP && $past(state) == S_SR_TRUE && $stable(dev_id))
        |-> tx_bit != $past(tx_bit)); // R6

    AST_UNKNOWN_KEEPS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD && byte_done && !bus_reset &&
         byte_val != OP_READ && byte_val != OP_MATCH && byte_val != OP_SEARCH &&
         byte_val != OP_SKIP && byte_val != OP_RESUME)
        |=> $stable(resume_flag) && !selected && !tx_active); // R10

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected); // R12
endmodule

// File: rtl/rom_selector.sv
// Single-wire ROM command selector top: joins the byte assembler, the
// identifier index counter and the controller. Assumes the bit engine
// delivers one-cycle strobes and consumes tx_bit on rd_done.
module rom_selector
    import rs_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] dev_id,
    input  logic            bus_reset,
    input  logic            wr_valid,
    input  logic            wr_bit,
    input  logic            rd_done,
    output logic            presence_pulse,
    output logic            tx_active,
    output logic            tx_bit,
    output logic            selected,
    output logic            resume_flag
);
    localparam int IW = $clog2(ID_W);

    logic             cmd_clr, cmd_en, byte_done;
    logic [CMD_W-1:0] byte_val;
    logic             idx_clr, idx_inc, last;
    logic [IW-1:0]    idx;

    rs_cmd_shift #(.W(CMD_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_clr),
        .en        (cmd_en),
        .bit_in    (wr_bit),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    rs_bit_index #(.N(ID_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (idx_inc),
        .idx   (idx),
        .last  (last)
    );

    rs_fsm #(.ID_W(ID_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .dev_id         (dev_id),
        .bus_reset      (bus_reset),
        .wr_valid       (wr_valid),
        .wr_bit         (wr_bit),
        .rd_done        (rd_done),
        .byte_done      (byte_done),
        .byte_val       (byte_val),
        .idx            (idx),
        .last           (last),
        .cmd_clr        (cmd_clr),
        .cmd_en         (cmd_en),
        .idx_clr        (idx_clr),
        .idx_inc        (idx_inc),
        .presence_pulse (presence_pulse),
        .selected       (selected),
        .resume_flag    (resume_flag),
        .tx_active      (tx_active),
        .tx_bit         (tx_bit)
    );
endmodule

// File: tb/rom_selector_test.sv
// Bench for rom_selector: command sweep, per-bit match and search sweeps,
// reads of several identifiers and reset interruption.
module rom_selector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_id = '0;
    logic        bus_reset = 1'b0, wr_valid = 1'b0, wr_bit = 1'b0, rd_done = 1'b0;
    logic        presence_pulse, tx_active, tx_bit, selected, resume_flag;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    rom_selector #(.ID_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .bus_reset(bus_reset),
        .wr_valid(wr_valid), .wr_bit(wr_bit), .rd_done(rd_done),
        .presence_pulse(presence_pulse), .tx_active(tx_active), .tx_bit(tx_bit),
        .selected(selected), .resume_flag(resume_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
        chk("R1 presence", {62'd0, presence_pulse, selected}, 64'h2);
        @(negedge clk);
        chk("R1 presence one cycle", {63'd0, presence_pulse}, 64'h0);
    endtask

    task automatic wbit(input logic b);
        @(negedge clk) begin wr_valid = 1'b1; wr_bit = b; end
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic rslot(output logic b);
        @(negedge clk) begin b = tx_bit; rd_done = 1'b1; end
        @(negedge clk) rd_done = 1'b0;
    endtask

    task automatic do_match(input logic [63:0] pat);
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(pat[i]);
    endtask

    task automatic preset_resume(input logic val);
        bus_rst();
        if (val) do_match(dev_id);
        else     wbyte(8'hCC);
        chk("R4/R8 preset", {63'd0, resume_flag}, {63'd0, val});
    endtask

    localparam logic [63:0] IDS [3] = '{64'hA7_0123456789AB_2C, 64'h5D_FFEEDDCCBBAA_01, 64'h00_80000000000F_FF};

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic b;
        logic [63:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dev_id = IDS[0];
        @(negedge clk);
        // R13: power-on state and commands ignored before first bus reset
        chk("R13 reset state", {59'd0, presence_pulse, tx_active, tx_bit, selected, resume_flag}, 64'h04);
        wbyte(8'hCC);
        chk("R13 skip before bus reset ignored", {63'd0, selected}, 64'h0);

        // R2 R8 R9 R10: sweep every command byte with resume flag clear and set
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] c;
                logic es, ea, er, eb;
                c = 8'(v);
                preset_resume(p[0]);
                bus_rst();
                wbyte(c);
                es = (c == 8'hCC) || (c == 8'hA5 && p == 1);
                ea = (c == 8'h33) || (c == 8'hF0);
                er = (c == 8'hCC || c == 8'h33) ? 1'b0 : p[0];
                eb = ea ? dev_id[0] : 1'b1;
                chk("R2 R8 R9 R10 decode", {60'd0, selected, tx_active, tx_bit, resume_flag},
                    {60'd0, es, ea, eb, er});
                if (!es && !ea && c != 8'h55) begin
                    wbyte(8'hCC);
                    rslot(b);
                    chk("R12 idle ignores bits", {61'd0, selected, tx_active, resume_flag},
                        {61'd0, 1'b0, 1'b0, p[0]});
                end
            end
        end

        for (int k = 0; k < 3; k++) begin
            dev_id = IDS[k];
            // R3: read sends identifier LSB first then selects, flag cleared
            preset_resume(1'b1);
            bus_rst();
            wbyte(8'h33);
            for (int i = 0; i < 64; i++) begin
                rslot(b);
                got[i] = b;
            end
            chk("R3 read identifier", got, dev_id);
            chk("R3 read selects, clears flag", {62'd0, selected, resume_flag}, 64'h2);
            // R12: selected ignores slots
            rslot(b);
            wbyte(8'h33);
            chk("R12 selected holds, line released", {61'd0, selected, tx_active, b}, 64'h5);
            // R4: full match
            preset_resume(1'b0);
            bus_rst();
            do_match(dev_id);
            chk("R4 match selects", {62'd0, selected, resume_flag}, 64'h3);
            // R11: resume flag survives reset, selection does not
            bus_rst();
            chk("R11 reset keeps flag, drops select", {62'd0, selected, resume_flag}, 64'h1);
            // R6: full search
            bus_rst();
            wbyte(8'hF0);
            for (int i = 0; i < 64; i++) begin
                logic t, cbit;
                rslot(t);
                rslot(cbit);
                got[i] = t;
                if (cbit !== ~t) chk("R6 complement slot", {63'd0, cbit}, {63'd0, ~t});
                wbit(t);
            end
            chk("R6 search true bits", got, dev_id);
            chk("R6 search selects", {62'd0, selected, resume_flag}, 64'h3);
        end

        dev_id = IDS[0];
        for (int i = 0; i < 64; i++) begin
            logic [63:0] bad;
            bad = dev_id ^ (64'd1 << i);
            // R5: mismatch at bit i, rest sent correctly
            preset_resume(1'b1);
            bus_rst();
            wbyte(8'h55);
            for (int j = 0; j < 64; j++) wbit(bad[j]);
            chk("R5 match mismatch", {62'd0, selected, resume_flag}, 64'h0);
            // R7: search dropout at bit i
            preset_resume(1'b1);
            bus_rst();
            wbyte(8'hF0);
            for (int j = 0; j < i; j++) begin
                rslot(b); rslot(b); wbit(dev_id[j]);
            end
            rslot(b); rslot(b); wbit(~dev_id[i]);
            rslot(b);
            chk("R7 search dropout", {60'd0, selected, tx_active, b, resume_flag}, 64'h2);
        end

        // R11: bus reset mid-read wins and restarts command collection
        preset_resume(1'b0);
        bus_rst();
        wbyte(8'h33);
        for (int i = 0; i < 20; i++) rslot(b);
        @(negedge clk) begin bus_reset = 1'b1; rd_done = 1'b1; end
        @(negedge clk) begin bus_reset = 1'b0; rd_done = 1'b0; end
        chk("R11 reset mid-read", {61'd0, presence_pulse, tx_active, selected}, 64'h4);
        @(negedge clk);
        wbyte(8'hCC);
        chk("R11 command after reset", {63'd0, selected}, 64'h1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule